// File: doc/BRIEF.md
# Indirect Register Access Window

This block is a small memory-mapped slave that gives a processor access to an interrupt router's configuration through only two addresses. One address holds an index register. The other address is a 32-bit data window. The index register chooses which internal word the window reads or writes. That word may be the router identifier, a read-only version word, an arbitration word that mirrors the identifier, or one half of a 64-bit routing-table entry.

The routing table is stored inside the block as two 32-bit memories, one for the low halves and one for the high halves. The router core reads whole entries through a separate synchronous read port. Each accepted window write into the table produces a one-cycle service pulse, which tells the router core to run a pass over its pending requests.

Bus requests are single-cycle: request, write flag, byte size, address and write data. A read returns its data with a valid strobe two cycles after the request is accepted. A write returns no response.

Top module: `regwin_top`

## Requirements
- R1: Only address bits [7:0] are decoded. Offset 0x00 is the index register and offset 0x10 is the data window. A read at any other offset returns 0, and a write at any other offset changes nothing.
- R2: The index register is 8 bits wide and resets to 0. A write at offset 0x00 loads write-data bits [7:0]. A read at offset 0x00 returns the index zero-extended to 32 bits.
- R3: A window access with a byte size other than 4 is ignored. Such a write leaves the identifier and the table unchanged and gives no service pulse. Such a read returns 0.
- R4: The identifier is 4 bits wide and resets to 0. A window write at index 0 stores write-data bits [27:24] and drops every other bit. A window read at index 0 or index 2 returns the identifier in bits [27:24], with all other bits 0.
- R5: A window read at index 1 returns 0x11 in bits [7:0] and the number of pins minus one in bits [23:16].
- R6: Window writes at index 1 and index 2 change nothing.
- R7: Index 0x10+2n selects the low 32 bits of table entry n, and index 0x11+2n selects the high 32 bits. A window write to one of these indices replaces only the selected half of the entry.
- R8: `svc_pulse` is high for exactly the one cycle after each accepted window write to a valid table index, and is low at all other times.
- R9: Indices 3 to 0x0F, and indices at or above 0x10 plus twice the pin count, read as 0. Writes to these indices change no state and give no service pulse.
- R10: Every read request gives exactly one `rsp_valid` cycle, two clock cycles after the request. A write request gives no response.
- R11: `core_entry` shows table entry `core_idx` one cycle after `core_idx` is presented, with the high half in bits [63:32]. It includes every write accepted before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request valid for this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Access size in bytes |
| req_addr | input | ADDR_W | Byte address; only bits [7:0] are decoded |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| svc_pulse | output | 1 | One-cycle service request after a table write |
| core_idx | input | IDX_W | Table entry selected by the router core |
| core_entry | output | 64 | Selected 64-bit table entry |

## Verification
The bench builds the block with 24 pins and a 12-bit address. With 24 pins the version word is 0x00170011, and the last valid table index is 0x3F. Index 0x40, the first index past the table, is therefore reachable and can be checked for dropped writes and zero reads. The 12-bit address lets the bench reach the window through an alias with upper address bits set, which shows that only bits [7:0] are decoded.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  // Classification of the current index register value.
  typedef enum logic [2:0] {
    KIND_ID,
    KIND_VER,
    KIND_ARB,
    KIND_TBL,
    KIND_NONE
  } win_kind_t;

  // Source of the data returned by a read, chosen in the first read stage.
  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_SEL,
    SRC_ID,
    SRC_VER,
    SRC_LO,
    SRC_HI
  } rd_src_t;

  // Maps the index classification to a read source.
  // The arbitration index reads the identifier.
  function automatic rd_src_t kind_to_src(win_kind_t k, logic upper);
    case (k)
      KIND_ID:  return SRC_ID;
      KIND_ARB: return SRC_ID;
      KIND_VER: return SRC_VER;
      KIND_TBL: return upper ? SRC_HI : SRC_LO;
      default:  return SRC_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int SEL_W    = 8,
  parameter int NUM_PINS = 24,
  parameter int TBL_BASE = 16,
  parameter int IDX_W    = 5
) (
  input  logic [SEL_W-1:0] sel,
  output win_kind_t        kind,
  output logic [IDX_W-1:0] idx,
  output logic             upper
);

  localparam logic [SEL_W-1:0] IDX_ID   = SEL_W'(0);
  localparam logic [SEL_W-1:0] IDX_VER  = SEL_W'(1);
  localparam logic [SEL_W-1:0] IDX_ARB  = SEL_W'(2);
  localparam logic [SEL_W-1:0] BASE     = SEL_W'(TBL_BASE);
  localparam logic [SEL_W:0]   TBL_SPAN = (SEL_W+1)'(2 * NUM_PINS);

  // Position inside the table range. Bit 0 picks the half, the rest picks the entry.
  logic [SEL_W-1:0] tbl_off;
  assign tbl_off = sel - BASE;

  always_comb begin
    kind  = KIND_NONE;
    idx   = '0;
    upper = 1'b0;
    if (sel == IDX_ID) begin
      kind = KIND_ID;
    end else if (sel == IDX_VER) begin
      kind = KIND_VER;
    end else if (sel == IDX_ARB) begin
      kind = KIND_ARB;
    end else if ((sel >= BASE) && ({1'b0, tbl_off} < TBL_SPAN)) begin
      kind  = KIND_TBL;
      idx   = IDX_W'(tbl_off >> 1);
      upper = tbl_off[0];
    end
  end

endmodule

// File: rtl/regwin_half_ram.sv
module regwin_half_ram #(
  parameter int DEPTH = 24,
  parameter int AW    = 5,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_q,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_q
);

  // One write port and two registered read ports, so it maps onto block RAM.
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    a_q <= mem[a_addr];
    b_q <= mem[b_addr];
  end

endmodule

// File: rtl/regwin_top.sv
module regwin_top
  import regwin_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          NUM_PINS  = 24,
  parameter int          SEL_W     = 8,
  parameter int          ID_W      = 4,
  parameter int          ID_LSB    = 24,
  parameter logic [7:0]  VER_CODE  = 8'h11,
  parameter int          ENT_LSB   = 16,
  parameter logic [7:0]  SEL_OFF   = 8'h00,
  parameter logic [7:0]  WIN_OFF   = 8'h10,
  parameter int          TBL_BASE  = 16,
  parameter int          WIN_BYTES = 4,
  parameter int          IDX_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [2:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              svc_pulse,
  input  logic [IDX_W-1:0]  core_idx,
  output logic [63:0]       core_entry
);

  localparam int          DEC_W    = 8;
  localparam logic [31:0] VER_WORD = 32'(VER_CODE) | (32'(NUM_PINS - 1) << ENT_LSB);

  // ---------------- address decode ----------------
  logic [DEC_W-1:0] off8;
  logic             hit_sel, hit_win, size_ok;
  assign off8    = req_addr[DEC_W-1:0];
  assign size_ok = (req_size == 3'(WIN_BYTES));
  assign hit_sel = (off8 == SEL_OFF);
  assign hit_win = (off8 == WIN_OFF) && size_ok;

  generate
    if (ADDR_W > DEC_W) begin : g_addr_hi
      logic addr_unused;
      assign addr_unused = ^req_addr[ADDR_W-1:DEC_W];
    end
  endgenerate

  // ---------------- index register and its decode ----------------
  logic [SEL_W-1:0] sel_q;
  logic [ID_W-1:0]  id_q;
  win_kind_t        kind;
  logic [IDX_W-1:0] tbl_idx;
  logic             tbl_upper;

  regwin_decode #(
    .SEL_W(SEL_W), .NUM_PINS(NUM_PINS), .TBL_BASE(TBL_BASE), .IDX_W(IDX_W)
  ) u_decode (
    .sel(sel_q), .kind(kind), .idx(tbl_idx), .upper(tbl_upper)
  );

  logic sel_wr, win_wr, tbl_wr, rd_req;
  assign sel_wr = req && req_wr && hit_sel;
  assign win_wr = req && req_wr && hit_win;
  assign tbl_wr = win_wr && (kind == KIND_TBL);
  assign rd_req = req && !req_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      id_q      <= '0;
      svc_pulse <= 1'b0;
    end else begin
      if (sel_wr) begin
        sel_q <= req_wdata[SEL_W-1:0];
      end
      if (win_wr && (kind == KIND_ID)) begin
        id_q <= req_wdata[ID_LSB +: ID_W];
      end
      svc_pulse <= tbl_wr;
    end
  end

  // ---------------- table storage, one memory per half ----------------
  logic [31:0]      win_q  [2];
  logic [31:0]      core_q [2];
  logic [IDX_W-1:0] win_ra;
  assign win_ra = (kind == KIND_TBL) ? tbl_idx : '0;

  generate
    for (genvar h = 0; h < 2; h++) begin : g_half
      regwin_half_ram #(
        .DEPTH(NUM_PINS), .AW(IDX_W), .DW(32)
      ) u_ram (
        .clk   (clk),
        .we    (tbl_wr && (tbl_upper == 1'(h))),
        .waddr (tbl_idx),
        .wdata (req_wdata),
        .a_addr(win_ra),
        .a_q   (win_q[h]),
        .b_addr(core_idx),
        .b_q   (core_q[h])
      );
    end
  endgenerate

  assign core_entry = {core_q[1], core_q[0]};

  // ---------------- two-stage read pipeline ----------------
  rd_src_t          src_d, s1_src;
  logic             s1_valid;
  logic [SEL_W-1:0] s1_sel;

  always_comb begin
    src_d = SRC_ZERO;
    if (hit_sel) begin
      src_d = SRC_SEL;
    end else if (hit_win) begin
      src_d = kind_to_src(kind, tbl_upper);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_src    <= SRC_ZERO;
      s1_sel    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      s1_valid  <= rd_req;
      s1_src    <= src_d;
      s1_sel    <= sel_q;
      rsp_valid <= s1_valid;
      if (s1_valid) begin
        case (s1_src)
          SRC_SEL: rsp_rdata <= 32'(s1_sel);
          SRC_ID:  rsp_rdata <= 32'(id_q) << ID_LSB;
          SRC_VER: rsp_rdata <= VER_WORD;
          SRC_LO:  rsp_rdata <= win_q[0];
          SRC_HI:  rsp_rdata <= win_q[1];
          default: rsp_rdata <= '0;
        endcase
      end
    end
  end

  // ---------------- assertions ----------------
  assert_sel_load_R2: assert property (@(posedge clk) disable iff (rst)
    sel_wr |=> (sel_q == $past(req_wdata[SEL_W-1:0])));

  assert_bad_size_keeps_id_R3: assert property (@(posedge clk) disable iff (rst)
    (req && req_wr && !size_ok) |=> $stable(id_q));

  assert_ver_arb_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (win_wr && ((kind == KIND_VER) || (kind == KIND_ARB))) |=> $stable(id_q));

  assert_svc_follows_write_R8: assert property (@(posedge clk) disable iff (rst)
    svc_pulse |-> $past(req && req_wr));

  assert_rsp_from_read_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req && !req_wr, 2));

  assert_write_silent_R10: assert property (@(posedge clk) disable iff (rst)
    (req && req_wr) |-> ##2 !rsp_valid);

endmodule

// File: tb/regwin_top_tb_top.sv
`timescale 1ns/1ps
module regwin_top_tb_top;

  localparam int NP = 24;
  localparam int AW = 12;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          req_wr = 1'b0;
  logic [2:0]    req_size = 3'd4;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          svc_pulse;
  logic [IW-1:0] core_idx = '0;
  logic [63:0]   core_entry;

  always #2.5 clk = ~clk;

  regwin_top #(.ADDR_W(AW), .NUM_PINS(NP)) dut_i (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .svc_pulse(svc_pulse), .core_idx(core_idx),
    .core_entry(core_entry)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- requirement model ----------------
  logic [7:0]  sel_m = 8'h00;
  logic [3:0]  id_m  = 4'h0;
  logic [31:0] lo_m [NP];
  logic [31:0] hi_m [NP];

  function automatic bit tbl_index(logic [7:0] s);
    return (s >= 8'h10) && (int'(s) < 16 + 2 * NP);
  endfunction

  function automatic logic [31:0] model_read(logic [2:0] sz, logic [AW-1:0] a);
    if (a[7:0] == 8'h00) return {24'h0, sel_m};
    if (a[7:0] != 8'h10 || sz != 3'd4) return 32'h0;
    if (sel_m == 8'h00 || sel_m == 8'h02) return {4'h0, id_m, 24'h0};
    if (sel_m == 8'h01) return 32'h0000_0011 | (32'(NP - 1) << 16);
    if (tbl_index(sel_m)) begin
      if (sel_m[0]) return hi_m[(int'(sel_m) - 16) / 2];
      return lo_m[(int'(sel_m) - 16) / 2];
    end
    return 32'h0;
  endfunction

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [31:0] exp;
    int          due;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R10 unexpected response", 64'(rsp_rdata), 64'h0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        chk(rsp_rdata == it.exp, it.tag, 64'(rsp_rdata), 64'(it.exp));
        chk(cyc == it.due, "R10 latency", 64'(cyc), 64'(it.due));
      end
    end
  end

  // Driver: called at a falling edge, returns at the next falling edge.
  task automatic rd(logic [2:0] sz, logic [AW-1:0] a, string tag);
    item_t it;
    it.exp = model_read(sz, a);
    it.due = cyc + 2;
    it.tag = tag;
    sb_q.push_back(it);
    req = 1'b1; req_wr = 1'b0; req_size = sz; req_addr = a; req_wdata = 32'h0;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic rd_lit(logic [2:0] sz, logic [AW-1:0] a, logic [31:0] lit, string tag);
    chk(model_read(sz, a) == lit, {tag, " model"}, 64'(model_read(sz, a)), 64'(lit));
    rd(sz, a, tag);
  endtask

  task automatic wr(logic [2:0] sz, logic [AW-1:0] a, logic [31:0] d, string tag);
    bit svc_exp = 1'b0;
    if (a[7:0] == 8'h00) begin
      sel_m = d[7:0];
    end else if (a[7:0] == 8'h10 && sz == 3'd4) begin
      if (sel_m == 8'h00) id_m = d[27:24];
      else if (tbl_index(sel_m)) begin
        svc_exp = 1'b1;
        if (sel_m[0]) hi_m[(int'(sel_m) - 16) / 2] = d;
        else lo_m[(int'(sel_m) - 16) / 2] = d;
      end
    end
    req = 1'b1; req_wr = 1'b1; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    chk(svc_pulse == svc_exp, {tag, " R8 svc_pulse"}, 64'(svc_pulse), 64'(svc_exp));
  endtask

  task automatic core_chk(int n, string tag);
    core_idx = IW'(n);
    @(negedge clk);
    chk(core_entry == {hi_m[n], lo_m[n]}, tag, core_entry, {hi_m[n], lo_m[n]});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    chk(svc_pulse == 1'b0, "R8 idle svc_pulse", 64'(svc_pulse), 64'h0);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (4) @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 reset rsp_valid", 64'(rsp_valid), 64'h0);
    chk(svc_pulse == 1'b0, "R8 reset svc_pulse", 64'(svc_pulse), 64'h0);
    rst = 1'b0;
    @(negedge clk);

    rd_lit(3'd4, 12'h000, 32'h0, "R2 reset index");
    rd_lit(3'd4, 12'h010, 32'h0, "R4 reset id");

    wr(3'd4, 12'h000, 32'hFFFF_FF01, "R2 load index");
    rd_lit(3'd4, 12'h000, 32'h0000_0001, "R2 index readback");
    rd_lit(3'd4, 12'h010, 32'h0017_0011, "R5 version word");

    wr(3'd4, 12'h000, 32'h0, "R2 index 0");
    wr(3'd4, 12'h010, 32'hFFFF_FFFF, "R4 id write");
    rd_lit(3'd4, 12'h010, 32'h0F00_0000, "R4 id masked");
    wr(3'd4, 12'h010, 32'h05FF_FFFF, "R4 id rewrite");
    wr(3'd4, 12'h000, 32'h2, "R2 index 2");
    rd_lit(3'd4, 12'h010, 32'h0500_0000, "R4 arb reads id");
    wr(3'd4, 12'h010, 32'h0A00_0000, "R6 arb write");
    wr(3'd4, 12'h000, 32'h1, "R2 index 1");
    wr(3'd4, 12'h010, 32'h0C00_00FF, "R6 version write");
    rd_lit(3'd4, 12'h010, 32'h0017_0011, "R6 version unchanged");
    wr(3'd4, 12'h000, 32'h0, "R2 index 0");
    rd_lit(3'd4, 12'h010, 32'h0500_0000, "R6 id unchanged");

    wr(3'd2, 12'h010, 32'h0300_0000, "R3 half-size write");
    wr(3'd1, 12'h010, 32'h0300_0000, "R3 byte write");
    rd_lit(3'd4, 12'h010, 32'h0500_0000, "R3 id kept");
    rd_lit(3'd2, 12'h010, 32'h0, "R3 half-size read");
    rd_lit(3'd0, 12'h010, 32'h0, "R3 zero-size read");

    wr(3'd4, 12'h000, 32'h10, "R7 index lo0");
    wr(3'd4, 12'h010, 32'h0000_A5A5, "R7 write lo0");
    wr(3'd4, 12'h000, 32'h11, "R7 index hi0");
    wr(3'd4, 12'h010, 32'h1234_5678, "R7 write hi0");
    rd_lit(3'd4, 12'h010, 32'h1234_5678, "R7 read hi0");
    wr(3'd4, 12'h000, 32'h10, "R7 index lo0");
    rd_lit(3'd4, 12'h010, 32'h0000_A5A5, "R7 read lo0");
    core_chk(0, "R11 entry 0");
    wr(3'd4, 12'h010, 32'hBEEF_0001, "R7 rewrite lo0");
    core_chk(0, "R7 hi half kept");

    wr(3'd4, 12'h000, 32'h3F, "R7 index hi23");
    wr(3'd4, 12'h010, 32'hCAFE_0023, "R7 write hi23");
    wr(3'd4, 12'h000, 32'h3E, "R7 index lo23");
    wr(3'd4, 12'h010, 32'h0000_0017, "R7 write lo23");
    core_chk(23, "R11 entry 23");
    wr(3'd4, 12'h000, 32'h13, "R7 index hi1");
    wr(3'd4, 12'h010, 32'h0101_0101, "R7 write hi1");
    wr(3'd4, 12'h000, 32'h12, "R7 index lo1");
    wr(3'd4, 12'h010, 32'h0202_0202, "R7 write lo1");
    core_chk(1, "R11 entry 1");

    // back-to-back reads
    wr(3'd4, 12'h000, 32'h3F, "R10 index hi23");
    rd(3'd4, 12'h010, "R10 burst hi23");
    rd(3'd4, 12'h000, "R10 burst index");
    rd(3'd4, 12'h010, "R10 burst hi23 again");
    rd(3'd4, 12'h004, "R10 burst other offset");
    idle(4);

    wr(3'd4, 12'h000, 32'h40, "R9 index past table");
    wr(3'd4, 12'h010, 32'hDEAD_BEEF, "R9 write past table");
    rd_lit(3'd4, 12'h010, 32'h0, "R9 read past table");
    core_chk(23, "R9 entry 23 kept");
    wr(3'd4, 12'h000, 32'h05, "R9 index gap");
    wr(3'd4, 12'h010, 32'h0F00_0000, "R9 write gap");
    rd_lit(3'd4, 12'h010, 32'h0, "R9 read gap");
    wr(3'd4, 12'h000, 32'hFF, "R9 index top");
    rd_lit(3'd4, 12'h010, 32'h0, "R9 read top");
    wr(3'd4, 12'h000, 32'h0, "R9 index 0");
    rd_lit(3'd4, 12'h010, 32'h0500_0000, "R9 id kept");

    wr(3'd4, 12'h004, 32'h0000_0033, "R1 write other offset");
    rd_lit(3'd4, 12'h000, 32'h0, "R1 index kept");
    rd_lit(3'd4, 12'h008, 32'h0, "R1 read other offset");
    wr(3'd4, 12'h700, 32'h0000_0011, "R1 alias index write");
    rd_lit(3'd4, 12'h000, 32'h0000_0011, "R1 alias index readback");
    wr(3'd4, 12'h310, 32'hFACE_0000, "R1 alias window write");
    rd_lit(3'd4, 12'h110, 32'hFACE_0000, "R1 alias window read");
    core_chk(0, "R1 entry 0 high via alias");

    idle(4);
    chk(sb_q.size() == 0, "R10 all responses returned", 64'(sb_q.size()), 64'h0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule